// File: doc/BRIEF.md
# Three-Key Combination Lock Controller

This block is a small Moore state machine that guards a three-key combination. Three key inputs and one clear input each arrive as single-cycle pulses from upstream pulse-shaping logic. Pressing key 1, then key 2, then key 3 (any number of idle cycles may separate the presses) opens the lock and raises `unlocked`. Any wrong key sends the machine into a latched fault state that raises `alarm`. Only the clear input, or the power-on reset, leaves the open or fault state.

The state is held one-hot in five flip-flops. The two outputs are wired straight from the bits for the open and fault states, so they carry no logic after the register. Both outputs change one clock edge after the press that causes the change.

Top module: `seq_lock`

## Requirements
- R1: While `rst_n` is low at a rising edge, the machine returns to the initial state and both outputs read 0 from that edge onward. This holds from any state, including open.
- R2: In the initial state, key 1 moves to the one-key state. Key 2 or key 3 moves to the fault state. A cycle with no key, or with only clear, stays in the initial state.
- R3: In the one-key state, key 2 moves to the two-key state and key 1 or key 3 moves to the fault state. Clear returns to the initial state, and a cycle with no key stays.
- R4: In the two-key state, key 3 moves to the open state, and `unlocked` is 1 after that edge. Key 1 or key 2 moves to the fault state. Clear returns to the initial state, and a cycle with no key stays.
- R5: The open and fault states ignore every key press, single or combined. Only clear, or reset, leaves them.
- R6: `unlocked` is 1 only in the open state, and `alarm` is 1 only in the fault state. The two are never 1 together, and exactly one state bit is set at all times (initial 00001, one-key 00010, two-key 00100, open 01000, fault 10000).
- R7: Clear takes priority over any keys pressed in the same cycle. From any state, it returns the machine to the initial state.
- R8: Two or more keys in the same cycle without clear count as a wrong entry. From the initial, one-key or two-key state, they move the machine to the fault state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low power-on reset |
| key1_pulse | input | 1 | Single-cycle pulse, first key of the combination |
| key2_pulse | input | 1 | Single-cycle pulse, second key |
| key3_pulse | input | 1 | Single-cycle pulse, third key |
| clear_pulse | input | 1 | Single-cycle pulse, returns to the initial state |
| unlocked | output | 1 | High while the lock is open |
| alarm | output | 1 | High while in the fault state |

## Verification
The one-key and two-key states cannot be seen at the outputs. The bench therefore follows each clear-with-key cycle with a probe press. A design that let the key win over clear would end up in the one-key state and answer a later key 2 with silence instead of an alarm. Combined presses are applied in every state. A design that decoded only the lowest set key would accept key 1 plus key 2 as a valid first digit, and one that did not latch the open state would drop `unlocked` or raise `alarm` when a stray key follows the opening. Reset is applied from the open state and in the middle of a partial sequence. A design that kept partial progress across reset would open on a lone key 3 instead of alarming.

// File: rtl/seq_lock_pkg.sv
// Shared constants and types for the combination lock.
// Assumes the three progress states occupy consecutive bit positions,
// so that advancing one step is a left shift of the one-hot code.
package seq_lock_pkg;
    localparam int NUM_KEYS   = 3;
    localparam int KEY_IDX_W  = $clog2(NUM_KEYS);
    localparam int HIT_W      = KEY_IDX_W + 1;
    localparam int NUM_STATES = NUM_KEYS + 2;

    // Bit positions of the one-hot state vector
    localparam int S_IDLE = 0;
    localparam int S_ONE  = 1;
    localparam int S_TWO  = 2;
    localparam int S_OPEN = NUM_KEYS;
    localparam int S_ERR  = NUM_KEYS + 1;

    typedef logic [NUM_STATES-1:0] state_t;

    localparam state_t CODE_IDLE = state_t'(1) << S_IDLE;
    localparam state_t CODE_ONE  = state_t'(1) << S_ONE;
    localparam state_t CODE_TWO  = state_t'(1) << S_TWO;
    localparam state_t CODE_OPEN = state_t'(1) << S_OPEN;
    localparam state_t CODE_ERR  = state_t'(1) << S_ERR;

    typedef enum logic [1:0] {
        EV_NONE   = 2'd0,
        EV_SINGLE = 2'd1,
        EV_MULTI  = 2'd2,
        EV_CLEAR  = 2'd3
    } ev_kind_t;

    typedef struct packed {
        ev_kind_t              kind;
        logic [KEY_IDX_W-1:0]  idx;
    } key_ev_t;
endpackage

// File: rtl/seq_lock_decode.sv
// Classifies the key and clear pulses of one cycle into a single event.
// Assumes each input is a clean single-cycle pulse. Clear outranks any keys,
// and more than one key counts as a multi-press.
module seq_lock_decode
    import seq_lock_pkg::*;
(
    input  logic [NUM_KEYS-1:0] keys_i,
    input  logic                clear_i,
    output key_ev_t             ev_o
);
    logic [HIT_W-1:0]     hits;
    logic [KEY_IDX_W-1:0] pos;

    // Count pressed keys and note the position of the last one found
    always_comb begin
        hits = '0;
        pos  = '0;
        for (int i = 0; i < NUM_KEYS; i++) begin
            if (keys_i[i]) begin
                hits = hits + HIT_W'(1);
                pos  = KEY_IDX_W'(i);
            end
        end
    end

    // Pick the event kind with clear at the highest priority
    always_comb begin
        ev_o.idx = pos;
        if (clear_i)
            ev_o.kind = EV_CLEAR;
        else if (hits == '0)
            ev_o.kind = EV_NONE;
        else if (hits > HIT_W'(1))
            ev_o.kind = EV_MULTI;
        else
            ev_o.kind = EV_SINGLE;
    end
endmodule

// File: rtl/seq_lock_next.sv
// Next-state function of the lock. Each progress state expects the key whose
// index equals its own bit position. The right key shifts the one-hot code up
// by one; any other key goes to the fault state. Open and fault are left only
// on clear. A code that is not legal falls into the fault state.
module seq_lock_next
    import seq_lock_pkg::*;
(
    input  state_t  cur_i,
    input  key_ev_t ev_i,
    output state_t  nxt_o
);
    logic                 in_progress;
    logic [KEY_IDX_W-1:0] want_idx;

    // Decode which key the current progress state is waiting for
    always_comb begin
        in_progress = 1'b1;
        want_idx    = '0;
        case (cur_i)
            CODE_IDLE: want_idx = KEY_IDX_W'(S_IDLE);
            CODE_ONE:  want_idx = KEY_IDX_W'(S_ONE);
            CODE_TWO:  want_idx = KEY_IDX_W'(S_TWO);
            default:   in_progress = 1'b0;
        endcase
    end

    // Select the next one-hot code from the current state and the event
    always_comb begin
        if (ev_i.kind == EV_CLEAR)
            nxt_o = CODE_IDLE;
        else if (cur_i == CODE_OPEN || cur_i == CODE_ERR)
            nxt_o = cur_i;
        else if (!in_progress)
            nxt_o = CODE_ERR;
        else if (ev_i.kind == EV_NONE)
            nxt_o = cur_i;
        else if (ev_i.kind == EV_SINGLE && ev_i.idx == want_idx)
            nxt_o = cur_i << 1;
        else
            nxt_o = CODE_ERR;
    end
endmodule

// File: rtl/seq_lock_state.sv
// One-hot state register with a synchronous active-low reset to the initial
// code. Assumes rst_n is already synchronous to clk.
module seq_lock_state
    import seq_lock_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  state_t d_i,
    output state_t q_o
);
    // Hold the state, forcing the initial code while reset is low
    always_ff @(posedge clk) begin
        if (!rst_n)
            q_o <= CODE_IDLE;
        else
            q_o <= d_i;
    end
endmodule

// File: rtl/seq_lock.sv
// Top of the three-key combination lock (Moore machine). The key pulses are
// classified, fed to the next-state function and stored one-hot. The outputs
// are taken straight from the open and fault bits. Assumes the inputs are
// single-cycle pulses synchronous to clk.
module seq_lock
    import seq_lock_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic key1_pulse,
    input  logic key2_pulse,
    input  logic key3_pulse,
    input  logic clear_pulse,
    output logic unlocked,
    output logic alarm
);
    logic [NUM_KEYS-1:0] keys;
    key_ev_t             ev;
    state_t              state_d;
    state_t              state_q;

    assign keys = {key3_pulse, key2_pulse, key1_pulse};

    seq_lock_decode u_decode (
        .keys_i  (keys),
        .clear_i (clear_pulse),
        .ev_o    (ev)
    );

    seq_lock_next u_next (
        .cur_i (state_q),
        .ev_i  (ev),
        .nxt_o (state_d)
    );

    seq_lock_state u_state (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (state_d),
        .q_o   (state_q)
    );

    assign unlocked = state_q[S_OPEN];
    assign alarm    = state_q[S_ERR];
endmodule

// File: rtl/seq_lock_chk.sv
// Assertion checker for seq_lock, attached through bind below. It watches
// the ports and the stored one-hot state.
module seq_lock_chk
    import seq_lock_pkg::*;
(
    input logic   clk,
    input logic   rst_n,
    input logic   key1_pulse,
    input logic   key2_pulse,
    input logic   key3_pulse,
    input logic   clear_pulse,
    input logic   unlocked,
    input logic   alarm,
    input state_t state_q
);
    logic [NUM_KEYS-1:0] keys;
    assign keys = {key3_pulse, key2_pulse, key1_pulse};

    // R6: exactly one state bit set
    p_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(state_q) == 1);

    // R6: outputs never both high
    p_exclusive_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(unlocked && alarm));

    // R7: clear wins and returns to initial
    p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        clear_pulse |=> (state_q == CODE_IDLE && !unlocked && !alarm));

    // R5: open stays open without clear
    p_open_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (unlocked && !clear_pulse) |=> unlocked);

    // R5: fault stays latched without clear
    p_alarm_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (alarm && !clear_pulse) |=> alarm);

    // R8: several keys at once in a progress state give the fault state
    p_multi_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear_pulse && $countones(keys) > 1 && !unlocked && !alarm) |=> alarm);

    // R4: opening only ever follows the two-key state
    p_open_path_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(unlocked) |-> $past(state_q == CODE_TWO));
endmodule

bind seq_lock seq_lock_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .key1_pulse  (key1_pulse),
    .key2_pulse  (key2_pulse),
    .key3_pulse  (key3_pulse),
    .clear_pulse (clear_pulse),
    .unlocked    (unlocked),
    .alarm       (alarm),
    .state_q     (state_q)
);

// File: tb/seq_lock_test.sv
module seq_lock_test;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 5000;
    localparam int NVEC       = 57;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic key1_pulse = 1'b0, key2_pulse = 1'b0, key3_pulse = 1'b0, clear_pulse = 1'b0;
    logic unlocked, alarm;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    seq_lock uut (
        .clk(clk), .rst_n(rst_n),
        .key1_pulse(key1_pulse), .key2_pulse(key2_pulse), .key3_pulse(key3_pulse),
        .clear_pulse(clear_pulse),
        .unlocked(unlocked), .alarm(alarm)
    );

    // Entry: {req[3:0], clear, k3, k2, k1, exp_unlocked, exp_alarm}
    localparam logic [9:0] VEC [NVEC] = '{
        {4'd2, 4'b0000, 2'b00},  //  0 R2 idle stays
        {4'd2, 4'b1000, 2'b00},  //  1 R2 clear in idle
        {4'd2, 4'b0001, 2'b00},  //  2 R2 k1 -> one
        {4'd3, 4'b0000, 2'b00},  //  3 R3 one holds
        {4'd3, 4'b0010, 2'b00},  //  4 R3 k2 -> two
        {4'd4, 4'b0000, 2'b00},  //  5 R4 two holds
        {4'd4, 4'b0100, 2'b10},  //  6 R4 k3 -> open
        {4'd5, 4'b0001, 2'b10},  //  7 R5 open ignores k1
        {4'd5, 4'b0110, 2'b10},  //  8 R5 open ignores combo
        {4'd7, 4'b1000, 2'b00},  //  9 R7 clear from open
        {4'd2, 4'b0010, 2'b01},  // 10 R2 k2 in idle -> fault
        {4'd5, 4'b0001, 2'b01},  // 11 R5 fault ignores k1
        {4'd5, 4'b0000, 2'b01},  // 12 R5 fault holds
        {4'd7, 4'b1001, 2'b00},  // 13 R7 clear+k1 -> idle
        {4'd7, 4'b0010, 2'b01},  // 14 R7 probe: idle, so k2 faults
        {4'd7, 4'b1000, 2'b00},  // 15
        {4'd2, 4'b0100, 2'b01},  // 16 R2 k3 in idle -> fault
        {4'd7, 4'b1000, 2'b00},  // 17
        {4'd3, 4'b0001, 2'b00},  // 18
        {4'd3, 4'b0001, 2'b01},  // 19 R3 k1 in one -> fault
        {4'd7, 4'b1000, 2'b00},  // 20
        {4'd3, 4'b0001, 2'b00},  // 21
        {4'd3, 4'b0100, 2'b01},  // 22 R3 k3 in one -> fault
        {4'd7, 4'b1000, 2'b00},  // 23
        {4'd3, 4'b0001, 2'b00},  // 24
        {4'd3, 4'b1000, 2'b00},  // 25 R3 clear in one
        {4'd3, 4'b0010, 2'b01},  // 26 R3 probe: back in idle
        {4'd7, 4'b1000, 2'b00},  // 27
        {4'd4, 4'b0001, 2'b00},  // 28
        {4'd4, 4'b0010, 2'b00},  // 29
        {4'd4, 4'b0001, 2'b01},  // 30 R4 k1 in two -> fault
        {4'd7, 4'b1000, 2'b00},  // 31
        {4'd4, 4'b0001, 2'b00},  // 32
        {4'd4, 4'b0010, 2'b00},  // 33
        {4'd4, 4'b0010, 2'b01},  // 34 R4 k2 in two -> fault
        {4'd7, 4'b1000, 2'b00},  // 35
        {4'd4, 4'b0001, 2'b00},  // 36
        {4'd4, 4'b0010, 2'b00},  // 37
        {4'd4, 4'b1000, 2'b00},  // 38 R4 clear in two
        {4'd4, 4'b0100, 2'b01},  // 39 R4 probe: idle, so k3 faults
        {4'd7, 4'b1000, 2'b00},  // 40
        {4'd8, 4'b0011, 2'b01},  // 41 R8 combo in idle
        {4'd7, 4'b1000, 2'b00},  // 42
        {4'd8, 4'b0001, 2'b00},  // 43
        {4'd8, 4'b0101, 2'b01},  // 44 R8 combo in one
        {4'd7, 4'b1000, 2'b00},  // 45
        {4'd8, 4'b0001, 2'b00},  // 46
        {4'd8, 4'b0010, 2'b00},  // 47
        {4'd8, 4'b0111, 2'b01},  // 48 R8 all keys in two
        {4'd7, 4'b1000, 2'b00},  // 49
        {4'd6, 4'b0001, 2'b00},  // 50
        {4'd6, 4'b0010, 2'b00},  // 51
        {4'd6, 4'b0100, 2'b10},  // 52 R6 open drives unlocked only
        {4'd7, 4'b1100, 2'b00},  // 53 R7 clear+k3 in open
        {4'd6, 4'b0001, 2'b00},  // 54
        {4'd6, 4'b0010, 2'b00},  // 55
        {4'd6, 4'b0100, 2'b10}   // 56 R6 reopen
    };

    task automatic check(input string req, input logic [1:0] got, input logic [1:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: {unlocked,alarm} = %b, expected %b", req, got, exp);
        end
    endtask

    // Apply one cycle of inputs at a falling edge; the outputs are read at the next falling edge
    task automatic press(input logic [3:0] ins);
        @(negedge clk);
        {clear_pulse, key3_pulse, key2_pulse, key1_pulse} = ins;
        @(negedge clk);
        {clear_pulse, key3_pulse, key2_pulse, key1_pulse} = 4'b0000;
    endtask

    initial begin
        #(CLK_PERIOD * WATCHDOG);
        fails++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 during reset", {unlocked, alarm}, 2'b00);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after release", {unlocked, alarm}, 2'b00);

        for (int v = 0; v < NVEC; v++) begin
            press(VEC[v][5:2]);
            check($sformatf("R%0d vector %0d", VEC[v][9:6], v), {unlocked, alarm}, VEC[v][1:0]);
            check("R6 exclusive", {1'b0, unlocked & alarm}, 2'b00);
        end

        // R1: reset from the open state
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 reset from open", {unlocked, alarm}, 2'b00);
        rst_n = 1'b1;
        press(4'b0010);
        check("R1 probe after reset: idle so k2 faults", {unlocked, alarm}, 2'b01);

        // R1: reset in the middle of a partial sequence discards the progress
        press(4'b1000);
        press(4'b0001);
        press(4'b0010);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        press(4'b0100);
        check("R1 partial progress cleared", {unlocked, alarm}, 2'b01);

        // R5: fault ignores every combo and holds over idle cycles
        press(4'b0111);
        check("R5 fault ignores all keys", {unlocked, alarm}, 2'b01);
        press(4'b0000);
        check("R5 fault holds", {unlocked, alarm}, 2'b01);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule